// File: doc/BRIEF.md
# Mode-Selectable Capture/Compare Unit

This unit sits next to a free-running 16-bit timer and does one of two jobs, picked by a 4-bit mode code. In a capture mode it watches an external input. On each qualified edge it copies the current timer value into a holding register. Edges can be divided down by 4 or by 16 before they count.

In a compare mode it checks the timer against a writable 16-bit compare value. On a match it can toggle the output pin, force the pin high or low, only raise the interrupt flag, or emit a one-cycle trigger pulse. The surrounding logic uses that pulse to clear the timer.

Every capture and every compare match sets a sticky interrupt flag. The flag stays set until a dedicated clear input is asserted. Any code that is not a capture or compare mode parks the unit: the pin goes low, the edge divider is emptied and no events occur.

Top module: `capcmp_unit`

## Requirements
- R1: After reset, `cap_value` is 0, `cmp_pin` is 0, `irq_flag` is 0 and `evt_trig` is 0.
- R2: Codes 0000, 0001, 0011 and 1100 to 1111 are idle. Under an idle code `cmp_pin` is driven low and the edge divider is cleared. No capture, no compare event and no flag set can occur.
- R3: `cap_in` goes through a two-stage synchroniser. A qualifying input change updates `cap_value` at the third rising clock edge after the change, and not earlier.
- R4: Code 0100 captures on every falling edge of `cap_in`, and rising edges have no effect. `cap_value` changes only on a capture.
- R5: Code 0101 captures on every rising edge of `cap_in`, and falling edges have no effect.
- R6: Code 0110 captures on every 4th rising edge, and code 0111 captures on every 16th rising edge.
- R7: Any change of the mode code clears the edge divider, so counting restarts from zero.
- R8: `cmp_wr_en` loads `cmp_wr_data` into the compare register. A match is an event only in the cycle the timer first equals the compare value. A match held over several cycles acts once, and a match already present in the cycle a mode is entered is not an event.
- R9: Code 0010 inverts `cmp_pin` on each match event. Entering it leaves the pin at its current level.
- R10: Entering code 1000 drives `cmp_pin` low, and a match then forces it high. Entering code 1001 drives `cmp_pin` high, and a match then forces it low.
- R11: Code 1010 sets `irq_flag` on a match and leaves `cmp_pin` unchanged.
- R12: Code 1011 raises `evt_trig` for exactly one cycle, after the clock edge at which a match occurs, and sets `irq_flag`.
- R13: `irq_flag` is sticky. It is set by every capture and every compare event. It is cleared by `irq_clear`, and a set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Mode code |
| tmr_value | input | 16 | Current timer count |
| cap_in | input | 1 | Asynchronous capture input |
| cmp_wr_en | input | 1 | Compare register load strobe |
| cmp_wr_data | input | 16 | Compare register load value |
| irq_clear | input | 1 | Clears the interrupt flag |
| cap_value | output | 16 | Last captured timer value |
| cmp_pin | output | 1 | Compare output pin |
| irq_flag | output | 1 | Sticky interrupt flag |
| evt_trig | output | 1 | One-cycle special-event trigger pulse |

## Verification
The hardest situation to reach is a divider holding a partial count at the moment the mode code changes.

The stimulus handles it in three steps:
- It sends two rising edges under the divide-by-4 code.
- It moves to the divide-by-16 code and then back to divide-by-4.
- It shows that three further edges capture nothing and the fourth does.

A leftover count would capture after only two edges. The other hard case is a timer value that stays equal to the compare value for several cycles. The bench holds it there and checks that the pin toggles only once.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    localparam int MODE_W           = 4;
    localparam int PRESC_LOG2_SMALL = 2;
    localparam int PRESC_LOG2_LARGE = 4;
    localparam int PRESC_CNT_W      = PRESC_LOG2_LARGE;

    typedef enum logic [MODE_W-1:0] {
        MD_OFF        = 4'b0000,
        MD_CMP_TOGGLE = 4'b0010,
        MD_CAP_FALL   = 4'b0100,
        MD_CAP_RISE   = 4'b0101,
        MD_CAP_RISE4  = 4'b0110,
        MD_CAP_RISE16 = 4'b0111,
        MD_CMP_HIGH   = 4'b1000,
        MD_CMP_LOW    = 4'b1001,
        MD_CMP_IRQ    = 4'b1010,
        MD_CMP_TRIG   = 4'b1011
    } mode_e;

    typedef struct packed {
        logic       cap_en;
        logic       cap_fall;
        logic [2:0] presc_log2;
        logic       cmp_en;
        logic       cmp_toggle;
        logic       cmp_force_hi;
        logic       cmp_force_lo;
        logic       cmp_trig;
    } mode_dec_t;

    function automatic mode_dec_t decode_mode(logic [MODE_W-1:0] code);
        mode_dec_t d;
        d = '0;
        case (code)
            MD_CAP_FALL:   begin d.cap_en = 1'b1; d.cap_fall = 1'b1; end
            MD_CAP_RISE:   d.cap_en = 1'b1;
            MD_CAP_RISE4:  begin d.cap_en = 1'b1; d.presc_log2 = 3'(PRESC_LOG2_SMALL); end
            MD_CAP_RISE16: begin d.cap_en = 1'b1; d.presc_log2 = 3'(PRESC_LOG2_LARGE); end
            MD_CMP_TOGGLE: begin d.cmp_en = 1'b1; d.cmp_toggle = 1'b1; end
            MD_CMP_HIGH:   begin d.cmp_en = 1'b1; d.cmp_force_hi = 1'b1; end
            MD_CMP_LOW:    begin d.cmp_en = 1'b1; d.cmp_force_lo = 1'b1; end
            MD_CMP_IRQ:    d.cmp_en = 1'b1;
            MD_CMP_TRIG:   begin d.cmp_en = 1'b1; d.cmp_trig = 1'b1; end
            default:       d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/capcmp_sync.sv
module capcmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/capcmp_capture.sv
module capcmp_capture #(
    parameter int TMR_W = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic             cap_fall,
    input  logic [2:0]       presc_log2,
    input  logic             mode_chg,
    input  logic             rise,
    input  logic             fall,
    input  logic [TMR_W-1:0] tmr_value,
    output logic [TMR_W-1:0] cap_value,
    output logic             cap_evt
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lmask;
    logic             qualified;
    logic             reached;

    assign lmask     = ~({CNT_W{1'b1}} << presc_log2);
    assign qualified = cap_en && !mode_chg && (cap_fall ? fall : rise);
    assign reached   = &(cnt | ~lmask);
    assign cap_evt   = qualified && reached;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            cap_value <= '0;
        end else begin
            if (!cap_en || mode_chg)
                cnt <= '0;
            else if (qualified)
                cnt <= reached ? '0 : cnt + 1'b1;
            if (cap_evt)
                cap_value <= tmr_value;
        end
    end
endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_en,
    input  logic             cmp_toggle,
    input  logic             cmp_force_hi,
    input  logic             cmp_force_lo,
    input  logic             cmp_trig,
    input  logic             mode_chg,
    input  logic [TMR_W-1:0] tmr_value,
    input  logic             wr_en,
    input  logic [TMR_W-1:0] wr_data,
    output logic             pin,
    output logic             trig,
    output logic             cmp_evt
);
    logic [TMR_W-1:0] cmp_reg;
    logic             match;
    logic             match_q;

    assign match   = (tmr_value == cmp_reg);
    assign cmp_evt = cmp_en && match && !match_q && !mode_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_reg <= '0;
            match_q <= 1'b0;
            pin     <= 1'b0;
            trig    <= 1'b0;
        end else begin
            if (wr_en)
                cmp_reg <= wr_data;
            match_q <= cmp_en && match;
            trig    <= cmp_evt && cmp_trig;
            if (!cmp_en) begin
                pin <= 1'b0;
            end else if (mode_chg) begin
                if (cmp_force_hi)      pin <= 1'b0;
                else if (cmp_force_lo) pin <= 1'b1;
            end else if (cmp_evt) begin
                if (cmp_toggle)        pin <= ~pin;
                else if (cmp_force_hi) pin <= 1'b1;
                else if (cmp_force_lo) pin <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit
    import capcmp_pkg::*;
#(
    parameter int TMR_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [TMR_W-1:0]  tmr_value,
    input  logic              cap_in,
    input  logic              cmp_wr_en,
    input  logic [TMR_W-1:0]  cmp_wr_data,
    input  logic              irq_clear,
    output logic [TMR_W-1:0]  cap_value,
    output logic              cmp_pin,
    output logic              irq_flag,
    output logic              evt_trig
);
    mode_dec_t         dec;
    logic [MODE_W-1:0] mode_q;
    logic              mode_chg;
    logic              rise;
    logic              fall;
    logic              cap_evt;
    logic              cmp_evt;

    assign dec      = decode_mode(mode);
    assign mode_chg = (mode != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MD_OFF;
            irq_flag <= 1'b0;
        end else begin
            mode_q <= mode;
            if (cap_evt || cmp_evt)
                irq_flag <= 1'b1;
            else if (irq_clear)
                irq_flag <= 1'b0;
        end
    end

    capcmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cap_in),
        .rise (rise),
        .fall (fall)
    );

    capcmp_capture #(.TMR_W(TMR_W), .CNT_W(PRESC_CNT_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .cap_en     (dec.cap_en),
        .cap_fall   (dec.cap_fall),
        .presc_log2 (dec.presc_log2),
        .mode_chg   (mode_chg),
        .rise       (rise),
        .fall       (fall),
        .tmr_value  (tmr_value),
        .cap_value  (cap_value),
        .cap_evt    (cap_evt)
    );

    capcmp_compare #(.TMR_W(TMR_W)) u_cmp (
        .clk          (clk),
        .rst          (rst),
        .cmp_en       (dec.cmp_en),
        .cmp_toggle   (dec.cmp_toggle),
        .cmp_force_hi (dec.cmp_force_hi),
        .cmp_force_lo (dec.cmp_force_lo),
        .cmp_trig     (dec.cmp_trig),
        .mode_chg     (mode_chg),
        .tmr_value    (tmr_value),
        .wr_en        (cmp_wr_en),
        .wr_data      (cmp_wr_data),
        .pin          (cmp_pin),
        .trig         (evt_trig),
        .cmp_evt      (cmp_evt)
    );
endmodule

// File: rtl/capcmp_checker.sv
module capcmp_checker #(
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       mode,
    input logic [3:0]       mode_q,
    input logic [TMR_W-1:0] cap_value,
    input logic             cmp_pin,
    input logic             irq_flag,
    input logic             irq_clear,
    input logic             evt_trig,
    input logic             cap_evt,
    input logic             cmp_evt
);
    logic idle_code;
    assign idle_code = (mode == 4'b0000) || (mode == 4'b0001) ||
                       (mode == 4'b0011) || (mode[3:2] == 2'b11);

    assert_idle_pin_low_R2: assert property (@(posedge clk) disable iff (rst)
        idle_code |=> !cmp_pin);

    assert_idle_no_event_R2: assert property (@(posedge clk) disable iff (rst)
        idle_code |-> !cap_evt && !cmp_evt);

    assert_capture_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !cap_evt |=> $stable(cap_value));

    assert_irq_mode_pin_R11: assert property (@(posedge clk) disable iff (rst)
        (mode == 4'b1010 && mode_q == 4'b1010) |=> $stable(cmp_pin));

    assert_trig_single_R12: assert property (@(posedge clk) disable iff (rst)
        evt_trig |=> !evt_trig);

    assert_trig_mode_R12: assert property (@(posedge clk) disable iff (rst)
        evt_trig |-> $past(mode) == 4'b1011);

    assert_flag_set_R13: assert property (@(posedge clk) disable iff (rst)
        (cap_evt || cmp_evt) |=> irq_flag);

    assert_flag_sticky_R13: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clear) |=> irq_flag);

    assert_flag_clear_R13: assert property (@(posedge clk) disable iff (rst)
        (irq_clear && !cap_evt && !cmp_evt) |=> !irq_flag);
endmodule

bind capcmp_unit capcmp_checker #(.TMR_W(TMR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .mode_q    (mode_q),
    .cap_value (cap_value),
    .cmp_pin   (cmp_pin),
    .irq_flag  (irq_flag),
    .irq_clear (irq_clear),
    .evt_trig  (evt_trig),
    .cap_evt   (cap_evt),
    .cmp_evt   (cmp_evt)
);

// File: tb/capcmp_unit_test.sv
module capcmp_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  mode;
    logic [15:0] tmr_value;
    logic        cap_in;
    logic        cmp_wr_en;
    logic [15:0] cmp_wr_data;
    logic        irq_clear;
    logic [15:0] cap_value;
    logic        cmp_pin;
    logic        irq_flag;
    logic        evt_trig;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    capcmp_unit uut (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .tmr_value   (tmr_value),
        .cap_in      (cap_in),
        .cmp_wr_en   (cmp_wr_en),
        .cmp_wr_data (cmp_wr_data),
        .irq_clear   (irq_clear),
        .cap_value   (cap_value),
        .cmp_pin     (cmp_pin),
        .irq_flag    (irq_flag),
        .evt_trig    (evt_trig)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic set_mode(logic [3:0] m);
        mode = m;
        tick();
    endtask

    task automatic in_pulse();
        cap_in = 1'b1;
        tick(4);
        cap_in = 1'b0;
        tick(4);
    endtask

    task automatic clr_irq();
        irq_clear = 1'b1;
        tick();
        irq_clear = 1'b0;
    endtask

    task automatic load_cmp(logic [15:0] v);
        cmp_wr_en   = 1'b1;
        cmp_wr_data = v;
        tick();
        cmp_wr_en   = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "cap_value", 32'(cap_value), 0);
        check("R1", "cmp_pin", 32'(cmp_pin), 0);
        check("R1", "irq_flag", 32'(irq_flag), 0);
        check("R1", "evt_trig", 32'(evt_trig), 0);
    endtask

    task automatic t_rise_latency();
        set_mode(4'b0101);
        tmr_value = 16'h1234;
        cap_in = 1'b1;
        tick(2);
        check("R3", "cap_value before third edge", 32'(cap_value), 0);
        tick();
        check("R3", "cap_value at third edge", 32'(cap_value), 32'h1234);
        check("R13", "flag after capture", 32'(irq_flag), 1);
        tmr_value = 16'h5555;
        cap_in = 1'b0;
        tick(4);
        check("R5", "falling edge ignored", 32'(cap_value), 32'h1234);
    endtask

    task automatic t_falling();
        set_mode(4'b0100);
        clr_irq();
        tmr_value = 16'h0AAA;
        cap_in = 1'b1;
        tick(4);
        check("R4", "rising edge ignored", 32'(cap_value), 32'h1234);
        check("R4", "no flag on ignored edge", 32'(irq_flag), 0);
        cap_in = 1'b0;
        tick(4);
        check("R4", "falling edge captured", 32'(cap_value), 32'h0AAA);
    endtask

    task automatic t_presc4();
        set_mode(4'b0110);
        for (int i = 1; i <= 4; i++) begin
            tmr_value = 16'h4000 + 16'(i);
            in_pulse();
            if (i == 3) check("R6", "no capture after 3 edges", 32'(cap_value), 32'h0AAA);
        end
        check("R6", "capture on 4th edge", 32'(cap_value), 32'h4004);
    endtask

    task automatic t_presc16();
        set_mode(4'b0111);
        for (int i = 1; i <= 16; i++) begin
            tmr_value = 16'h6000 + 16'(i);
            in_pulse();
            if (i == 15) check("R6", "no capture after 15 edges", 32'(cap_value), 32'h4004);
        end
        check("R6", "capture on 16th edge", 32'(cap_value), 32'h6010);
    endtask

    task automatic t_presc_clear();
        set_mode(4'b0110);
        tmr_value = 16'h7001;
        in_pulse();
        in_pulse();
        set_mode(4'b0111);
        set_mode(4'b0110);
        for (int i = 1; i <= 4; i++) begin
            tmr_value = 16'h7100 + 16'(i);
            in_pulse();
            if (i == 3) check("R7", "divider restarted after mode change", 32'(cap_value), 32'h6010);
        end
        check("R7", "capture on 4th edge after change", 32'(cap_value), 32'h7104);
    endtask

    task automatic t_idle_codes();
        logic [3:0] codes [3] = '{4'b0001, 4'b0011, 4'b1100};
        clr_irq();
        foreach (codes[k]) begin
            set_mode(codes[k]);
            tmr_value = 16'h9900 + 16'(k);
            in_pulse();
            check("R2", "idle code no capture", 32'(cap_value), 32'h7104);
            check("R2", "idle code no flag", 32'(irq_flag), 0);
        end
    endtask

    task automatic t_toggle();
        tmr_value = 16'h0000;
        load_cmp(16'h0100);
        set_mode(4'b0010);
        clr_irq();
        tmr_value = 16'h0100;
        tick();
        check("R9", "toggle to high", 32'(cmp_pin), 1);
        check("R13", "flag on match", 32'(irq_flag), 1);
        tick(3);
        check("R8", "held match acts once", 32'(cmp_pin), 1);
        tmr_value = 16'h0101;
        tick();
        tmr_value = 16'h0100;
        tick();
        check("R9", "toggle back low", 32'(cmp_pin), 0);
    endtask

    task automatic t_force();
        tmr_value = 16'h0000;
        tick();
        set_mode(4'b1001);
        check("R10", "entry of 1001 drives high", 32'(cmp_pin), 1);
        set_mode(4'b1000);
        check("R10", "entry of 1000 drives low", 32'(cmp_pin), 0);
        tmr_value = 16'h0100;
        tick();
        check("R10", "1000 match forces high", 32'(cmp_pin), 1);
        tmr_value = 16'h0000;
        set_mode(4'b1001);
        check("R10", "re-entry of 1001 high", 32'(cmp_pin), 1);
        tmr_value = 16'h0100;
        tick();
        check("R10", "1001 match forces low", 32'(cmp_pin), 0);
    endtask

    task automatic t_irq_only();
        tmr_value = 16'h0000;
        set_mode(4'b1000);
        tmr_value = 16'h0100;
        tick();
        tmr_value = 16'h0000;
        set_mode(4'b1010);
        clr_irq();
        check("R11", "pin kept on entry", 32'(cmp_pin), 1);
        tmr_value = 16'h0100;
        tick();
        check("R11", "flag set on match", 32'(irq_flag), 1);
        check("R11", "pin unchanged on match", 32'(cmp_pin), 1);
    endtask

    task automatic t_trigger();
        tmr_value = 16'h0000;
        set_mode(4'b1011);
        clr_irq();
        check("R12", "no pulse before match", 32'(evt_trig), 0);
        tmr_value = 16'h0100;
        tick();
        check("R12", "pulse after match edge", 32'(evt_trig), 1);
        check("R12", "flag set with pulse", 32'(irq_flag), 1);
        tmr_value = 16'h0000;
        tick();
        check("R12", "pulse lasts one cycle", 32'(evt_trig), 0);
    endtask

    task automatic t_idle_pin();
        set_mode(4'b1001);
        check("R2", "pin high before idle", 32'(cmp_pin), 1);
        set_mode(4'b0000);
        check("R2", "idle drives pin low", 32'(cmp_pin), 0);
    endtask

    task automatic t_flag_priority();
        set_mode(4'b0101);
        clr_irq();
        check("R13", "flag cleared", 32'(irq_flag), 0);
        tmr_value = 16'hBEEF;
        cap_in = 1'b1;
        tick(2);
        irq_clear = 1'b1;
        tick();
        irq_clear = 1'b0;
        check("R13", "set wins over clear", 32'(irq_flag), 1);
        check("R5", "capture in same cycle", 32'(cap_value), 32'hBEEF);
        tick(2);
        check("R13", "flag stays set", 32'(irq_flag), 1);
        clr_irq();
        check("R13", "flag clears", 32'(irq_flag), 0);
        cap_in = 1'b0;
        tick(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        mode = 4'b0000;
        tmr_value = '0;
        cap_in = 1'b0;
        cmp_wr_en = 1'b0;
        cmp_wr_data = '0;
        irq_clear = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_rise_latency();
        t_falling();
        t_presc4();
        t_presc16();
        t_presc_clear();
        t_idle_codes();
        t_toggle();
        t_force();
        t_irq_only();
        t_trigger();
        t_idle_pin();
        t_flag_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule